// File: doc/BRIEF.md
# Multi-Mode Waveform Timer-Counter

This block is a timer-counter with a single compare channel. One counter is shared by five waveform modes: free-running up-counting, clear-on-match period generation, single-slope PWM, and two dual-slope PWM variants. The two dual-slope variants differ only in when a new compare value takes effect. The counter advances only on a one-cycle count tick. The tick comes from an external prescaler strobe, or from the rising or falling edge of an external input that the block synchronizes itself.

The compare value is written through a simple write strobe. In the PWM modes the write goes into a holding buffer, and the active comparator picks it up at a point in the period chosen by the mode. The compare output has a 2-bit action field and a force strobe. Sticky overflow and match flags drive interrupt requests through enables.

Top module: `wave_timer`

## Requirements
- R1: After reset, count is 0. oc_out, oc_en, ov_flag, cm_flag, ov_irq and cm_irq are all 0.
- R2: tick_src selects the count tick: 00 stops the count, 01 uses pre_tick, 10 uses a rising edge of ext_in and 11 uses a falling edge of ext_in. ext_in passes through two synchronizer flops, and each selected edge advances the count by exactly one.
- R3: In mode 0 (normal, also codes 5 to 7) the count rises by one per tick and wraps from all ones to 0. ov_flag is set on that wrap.
- R4: In mode 1 (clear on match), a tick while count equals the compare value k loads 0. The count repeats 0..k with period k+1 ticks, and cm_flag is set on each match.
- R5: In modes 0 and 1 a compare match applies the com action: 01 toggles oc_out, 10 clears it and 11 sets it. oc_en is 1 whenever com is not 00.
- R6: With com = 00, oc_en is 0 and oc_out never changes, whatever matches occur.
- R7: A one-cycle force_cmp in modes 0 and 1 applies the com action on the next clock edge. It does not set cm_flag and does not change the count. In modes 2 to 4, force_cmp has no effect on oc_out.
- R8: In mode 2 (fast PWM) the count runs 0..MAX and wraps, setting ov_flag. With com = 10, oc_out is set on the wrap and cleared on a match, and the set wins if both happen on one tick. oc_out is then high for k+1 of every 2^W ticks. com = 11 gives the complement, and oc_en = com[1].
- R9: In mode 3 (phase-correct PWM) the count climbs 0..MAX and falls back, a period of 2*MAX ticks, and ov_flag is set at the bottom turn. With com = 10, a match on a rising step clears oc_out and a match on a falling step sets it, so oc_out is high for 2k of 2*MAX ticks. com = 11 gives the complement.
- R10: In mode 2 and mode 3 a written compare value takes effect on the tick at count MAX. In mode 4 it takes effect on the tick at count 0. In modes 0 and 1 it takes effect on the next cycle.
- R11: Mode 4 (phase-and-frequency-correct PWM) produces the same dual-slope count and duty as mode 3 while the compare value is held constant.
- R12: ov_flag and cm_flag stay set until a one-cycle ov_clr or cm_clr. A set in the same cycle wins over the clear. ov_irq = ov_flag AND ov_ie, and cm_irq = cm_flag AND cm_ie.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src | input | 2 | Count tick source select |
| pre_tick | input | 1 | Prescaler strobe, one cycle wide |
| ext_in | input | 1 | Asynchronous external count input |
| mode | input | 3 | Waveform mode |
| com | input | 2 | Compare output action field |
| ocr_wdata | input | CNT_W | Compare value write data |
| ocr_we | input | 1 | Compare value write strobe |
| force_cmp | input | 1 | Force compare action strobe |
| ov_ie | input | 1 | Overflow interrupt enable |
| cm_ie | input | 1 | Match interrupt enable |
| ov_clr | input | 1 | Overflow flag clear strobe |
| cm_clr | input | 1 | Match flag clear strobe |
| count | output | CNT_W | Counter value |
| oc_out | output | 1 | Compare output register |
| oc_en | output | 1 | Compare output drive enable |
| ov_flag | output | 1 | Sticky overflow flag |
| cm_flag | output | 1 | Sticky compare match flag |
| ov_irq | output | 1 | Overflow interrupt request |
| cm_irq | output | 1 | Match interrupt request |

## Verification
The bench uses a 4-bit counter and sweeps every compare value through fast PWM (both polarities), phase-correct and phase-and-frequency-correct PWM. For each case it counts the high cycles over one full period. These duty counts separate the set-over-clear priority at the extremes and the rising-versus-falling match handling. Clear-on-match periods are measured for every compare value, which exposes off-by-one errors in the clear. A compare write in the middle of a period separates load at the top from load at the bottom, and a second one confirms the buffering in fast PWM. Strobed prescaler ticks and ext_in edges of both polarities check that each source produces exactly one count per event.

// File: rtl/wtmr_pkg.sv
package wtmr_pkg;

  typedef enum logic [2:0] {
    WM_NORMAL = 3'd0,
    WM_CTC    = 3'd1,
    WM_FAST   = 3'd2,
    WM_PCORR  = 3'd3,
    WM_PFCORR = 3'd4
  } wmode_e;

  typedef enum logic [1:0] {
    TS_STOP     = 2'd0,
    TS_PRESCALE = 2'd1,
    TS_EXT_RISE = 2'd2,
    TS_EXT_FALL = 2'd3
  } tsrc_e;

  // unused codes fall back to normal counting
  function automatic wmode_e decode_mode(input logic [2:0] m);
    case (m)
      3'd1:    return WM_CTC;
      3'd2:    return WM_FAST;
      3'd3:    return WM_PCORR;
      3'd4:    return WM_PFCORR;
      default: return WM_NORMAL;
    endcase
  endfunction

  function automatic logic mode_is_pwm(input wmode_e m);
    return (m == WM_FAST) || (m == WM_PCORR) || (m == WM_PFCORR);
  endfunction

  function automatic logic mode_is_dual(input wmode_e m);
    return (m == WM_PCORR) || (m == WM_PFCORR);
  endfunction

  // non-PWM compare action applied to the current output value
  function automatic logic np_action(input logic [1:0] c, input logic cur);
    case (c)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/wtmr_tick_sel.sv
module wtmr_tick_sel
  import wtmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tick_src,
  input  logic       pre_tick,
  input  logic       ext_in,
  output logic       tick
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] ext_sh;
  logic            ext_now;
  logic            ext_prev;
  logic            ext_rise;
  logic            ext_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sh <= '0;
    else        ext_sh <= {ext_sh[SH_W-2:0], ext_in};
  end

  always_comb begin
    ext_now  = ext_sh[SYNC_STAGES-1];
    ext_prev = ext_sh[SYNC_STAGES];
    ext_rise = ext_now & ~ext_prev;
    ext_fall = ~ext_now & ext_prev;
    case (tsrc_e'(tick_src))
      TS_PRESCALE: tick = pre_tick;
      TS_EXT_RISE: tick = ext_rise;
      TS_EXT_FALL: tick = ext_fall;
      default:     tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/wtmr_counter.sv
module wtmr_counter
  import wtmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  wmode_e           mode_d,
  input  logic             cmp_eq,
  output logic [CNT_W-1:0] count,
  output logic             at_max,
  output logic             at_zero,
  output logic             step_up,
  output logic             ov_evt
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic             dir_up;
  logic             dual;
  logic [CNT_W-1:0] cnt_nx;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v, input logic up);
    return up ? v + 1'b1 : v - 1'b1;
  endfunction

  always_comb begin
    at_max  = (count == MAXV);
    at_zero = (count == '0);
    dual    = mode_is_dual(mode_d);
    step_up = dual ? ((dir_up && !at_max) || (!dir_up && at_zero)) : 1'b1;
    ov_evt  = tick && (dual ? (at_zero && !dir_up) : at_max);
    if (!dual && mode_d == WM_CTC && cmp_eq) cnt_nx = '0;
    else                                     cnt_nx = step(count, step_up);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else if (tick) begin
      count  <= cnt_nx;
      dir_up <= step_up;
    end
  end
endmodule

// File: rtl/wtmr_compare.sv
module wtmr_compare
  import wtmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  wmode_e           mode_d,
  input  logic [CNT_W-1:0] count,
  input  logic             at_max,
  input  logic             at_zero,
  input  logic [CNT_W-1:0] ocr_wdata,
  input  logic             ocr_we,
  output logic [CNT_W-1:0] ocr_act,
  output logic             cmp_eq,
  output logic             match
);
  logic [CNT_W-1:0] ocr_buf;
  logic             load_pt;

  always_comb begin
    cmp_eq = (count == ocr_act);
    match  = tick && cmp_eq;
    case (mode_d)
      WM_FAST, WM_PCORR: load_pt = tick && at_max;
      WM_PFCORR:         load_pt = tick && at_zero;
      default:           load_pt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr_buf <= '0;
      ocr_act <= '0;
    end else begin
      if (ocr_we) ocr_buf <= ocr_wdata;
      if (!mode_is_pwm(mode_d)) ocr_act <= ocr_we ? ocr_wdata : ocr_buf;
      else if (load_pt)         ocr_act <= ocr_buf;
    end
  end
endmodule

// File: rtl/wtmr_wavegen.sv
module wtmr_wavegen
  import wtmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  wmode_e     mode_d,
  input  logic [1:0] com,
  input  logic       tick,
  input  logic       match,
  input  logic       force_cmp,
  input  logic       at_max,
  input  logic       step_up,
  input  logic       ov_evt,
  input  logic       ov_clr,
  input  logic       cm_clr,
  input  logic       ov_ie,
  input  logic       cm_ie,
  output logic       oc_out,
  output logic       oc_en,
  output logic       ov_flag,
  output logic       cm_flag,
  output logic       ov_irq,
  output logic       cm_irq
);
  logic pwm;
  logic inv;
  logic wrap_evt;
  logic oc_nx;

  always_comb begin
    pwm      = mode_is_pwm(mode_d);
    inv      = com[0];
    wrap_evt = tick && at_max;
    oc_en    = pwm ? com[1] : (com != 2'b00);
    oc_nx    = oc_out;
    if (!pwm) begin
      if (match || force_cmp) oc_nx = np_action(com, oc_out);
    end else if (com[1]) begin
      if (mode_d == WM_FAST) begin
        if (wrap_evt)   oc_nx = ~inv;
        else if (match) oc_nx = inv;
      end else if (match) begin
        oc_nx = step_up ? inv : ~inv;
      end
    end
    ov_irq = ov_flag & ov_ie;
    cm_irq = cm_flag & cm_ie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_out  <= 1'b0;
      ov_flag <= 1'b0;
      cm_flag <= 1'b0;
    end else begin
      oc_out <= oc_nx;
      if (ov_evt)      ov_flag <= 1'b1;
      else if (ov_clr) ov_flag <= 1'b0;
      if (match)       cm_flag <= 1'b1;
      else if (cm_clr) cm_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wtmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       tick_src,
  input  logic             pre_tick,
  input  logic             ext_in,
  input  logic [2:0]       mode,
  input  logic [1:0]       com,
  input  logic [CNT_W-1:0] ocr_wdata,
  input  logic             ocr_we,
  input  logic             force_cmp,
  input  logic             ov_ie,
  input  logic             cm_ie,
  input  logic             ov_clr,
  input  logic             cm_clr,
  output logic [CNT_W-1:0] count,
  output logic             oc_out,
  output logic             oc_en,
  output logic             ov_flag,
  output logic             cm_flag,
  output logic             ov_irq,
  output logic             cm_irq
);
  wmode_e           mode_d;
  logic             tick;
  logic             at_max;
  logic             at_zero;
  logic             step_up;
  logic             ov_evt;
  logic             cmp_eq;
  logic             match;
  logic [CNT_W-1:0] ocr_act;

  assign mode_d = decode_mode(mode);

  wtmr_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .pre_tick(pre_tick),
    .ext_in(ext_in), .tick(tick)
  );

  wtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_d(mode_d), .cmp_eq(cmp_eq),
    .count(count), .at_max(at_max), .at_zero(at_zero), .step_up(step_up),
    .ov_evt(ov_evt)
  );

  wtmr_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_d(mode_d), .count(count),
    .at_max(at_max), .at_zero(at_zero), .ocr_wdata(ocr_wdata), .ocr_we(ocr_we),
    .ocr_act(ocr_act), .cmp_eq(cmp_eq), .match(match)
  );

  wtmr_wavegen u_wave (
    .clk(clk), .rst_n(rst_n), .mode_d(mode_d), .com(com), .tick(tick),
    .match(match), .force_cmp(force_cmp), .at_max(at_max), .step_up(step_up),
    .ov_evt(ov_evt), .ov_clr(ov_clr), .cm_clr(cm_clr), .ov_ie(ov_ie),
    .cm_ie(cm_ie), .oc_out(oc_out), .oc_en(oc_en), .ov_flag(ov_flag),
    .cm_flag(cm_flag), .ov_irq(ov_irq), .cm_irq(cm_irq)
  );
endmodule

// File: rtl/wtmr_chk.sv
module wtmr_chk
  import wtmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       tick_src,
  input logic             tick,
  input wmode_e           mode_d,
  input logic [1:0]       com,
  input logic [CNT_W-1:0] count,
  input logic             cmp_eq,
  input logic             match,
  input logic             force_cmp,
  input logic             oc_out,
  input logic             ov_evt,
  input logic             ov_flag,
  input logic             ov_clr,
  input logic             cm_flag
);
  // R2
  tick_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_src == 2'b00 |=> $stable(count));

  // R4
  ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_d == WM_CTC && tick && cmp_eq) |=> count == '0);

  // R6
  com_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    com == 2'b00 |=> $stable(oc_out));

  // R7
  force_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_pwm(mode_d) && force_cmp && !tick) |=> $stable(oc_out));

  // R7
  force_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_cmp && !match && !cm_flag) |=> !cm_flag);

  // R9
  dual_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_dual(mode_d) && tick) |=>
      (count == $past(count) + 1'b1 || count == $past(count) - 1'b1));

  // R3
  ov_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_evt |=> ov_flag);

  // R12
  ov_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag && !ov_clr) |=> ov_flag);
endmodule

bind wave_timer wtmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .tick(tick), .mode_d(mode_d),
  .com(com), .count(count), .cmp_eq(cmp_eq), .match(match),
  .force_cmp(force_cmp), .oc_out(oc_out), .ov_evt(ov_evt), .ov_flag(ov_flag),
  .ov_clr(ov_clr), .cm_flag(cm_flag)
);

// File: tb/sim_wave_timer.sv
`timescale 1ns/1ps
module sim_wave_timer;
  localparam int W    = 4;
  localparam int MAXV = (1 << W) - 1;
  localparam int FULL = 1 << W;
  localparam int DPER = 2 * MAXV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] tick_src = 2'b01;
  logic pre_tick = 1'b1;
  logic ext_in = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [1:0] com = 2'b00;
  logic [W-1:0] ocr_wdata = '0;
  logic ocr_we = 1'b0;
  logic force_cmp = 1'b0;
  logic ov_ie = 1'b0, cm_ie = 1'b0, ov_clr = 1'b0, cm_clr = 1'b0;
  logic [W-1:0] count;
  logic oc_out, oc_en, ov_flag, cm_flag, ov_irq, cm_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wave_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .pre_tick(pre_tick),
    .ext_in(ext_in), .mode(mode), .com(com), .ocr_wdata(ocr_wdata),
    .ocr_we(ocr_we), .force_cmp(force_cmp), .ov_ie(ov_ie), .cm_ie(cm_ie),
    .ov_clr(ov_clr), .cm_clr(cm_clr), .count(count), .oc_out(oc_out),
    .oc_en(oc_en), .ov_flag(ov_flag), .cm_flag(cm_flag), .ov_irq(ov_irq),
    .cm_irq(cm_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ocr(input int v);
    ocr_wdata = W'(v);
    ocr_we = 1'b1;
    @(negedge clk);
    ocr_we = 1'b0;
  endtask

  task automatic wait_count(input int v);
    while (int'(count) != v) @(negedge clk);
  endtask

  function automatic int highs_fast(input int k, input bit inv);
    return inv ? FULL - (k + 1) : k + 1;
  endfunction

  function automatic int highs_dual(input int k, input bit inv);
    return inv ? DPER - 2 * k : 2 * k;
  endfunction

  task automatic measure(input int win, output int hi);
    hi = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      hi += int'(oc_out);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hi, c0, n, v0;
    cyc(3);
    // R1 reset state
    check("R1 count", int'(count), 0);
    check("R1 outputs", int'({oc_out, oc_en, ov_flag, cm_flag, ov_irq, cm_irq}), 0);
    rst_n = 1'b1;

    // R3 normal counting and wrap flag
    ov_ie = 1'b1;
    cyc(15);
    check("R3 count at MAX", int'(count), MAXV);
    check("R3 no flag before wrap", int'(ov_flag), 0);
    cyc(1);
    check("R3 wrap count", int'(count), 0);
    check("R3 flag on wrap", int'(ov_flag), 1);
    check("R12 ov_irq", int'(ov_irq), 1);
    cyc(5);
    check("R12 flag sticky", int'(ov_flag), 1);
    ov_clr = 1'b1; cyc(1); ov_clr = 1'b0;
    check("R12 flag cleared", int'(ov_flag), 0);
    ov_ie = 1'b0;

    // R2 stopped, strobed, external edges
    tick_src = 2'b00; cyc(2);
    c0 = int'(count);
    cyc(20);
    check("R2 stop holds", int'(count), c0);
    pre_tick = 1'b0; tick_src = 2'b01;
    for (int i = 0; i < 7; i++) begin
      pre_tick = 1'b1; cyc(1); pre_tick = 1'b0; cyc(2);
    end
    check("R2 prescale pulses", int'(count), (c0 + 7) % FULL);
    c0 = int'(count);
    tick_src = 2'b10;
    for (int i = 0; i < 5; i++) begin
      ext_in = 1'b1; cyc(4); ext_in = 1'b0; cyc(4);
    end
    cyc(6);
    check("R2 rising edges", int'(count), (c0 + 5) % FULL);
    c0 = int'(count);
    tick_src = 2'b11;
    for (int i = 0; i < 5; i++) begin
      ext_in = 1'b1; cyc(4); ext_in = 1'b0; cyc(4);
    end
    cyc(6);
    check("R2 falling edges", int'(count), (c0 + 5) % FULL);
    pre_tick = 1'b1; tick_src = 2'b01;

    // R5 non-PWM compare actions
    mode = 3'd0; wr_ocr(5); com = 2'b01; cyc(1);
    v0 = int'(oc_out);
    cyc(16);
    check("R5 toggle", int'(oc_out), 1 - v0);
    check("R5 oc_en", int'(oc_en), 1);
    com = 2'b11; cyc(16);
    check("R5 set", int'(oc_out), 1);
    com = 2'b10; cyc(16);
    check("R5 clear", int'(oc_out), 0);

    // R6 disconnected output
    com = 2'b11; cyc(16);
    com = 2'b00; cyc(40);
    check("R6 output unchanged", int'(oc_out), 1);
    check("R6 oc_en off", int'(oc_en), 0);

    // R7 force in non-PWM and PWM modes
    tick_src = 2'b00; com = 2'b01; cm_clr = 1'b1; cyc(1); cm_clr = 1'b0;
    c0 = int'(count); v0 = int'(oc_out);
    force_cmp = 1'b1; cyc(1); force_cmp = 1'b0;
    check("R7 force toggles", int'(oc_out), 1 - v0);
    check("R7 force no flag", int'(cm_flag), 0);
    check("R7 force keeps count", int'(count), c0);
    mode = 3'd2; com = 2'b10; cyc(1);
    v0 = int'(oc_out);
    force_cmp = 1'b1; cyc(1); force_cmp = 1'b0; cyc(1);
    check("R7 force ignored in PWM", int'(oc_out), v0);
    tick_src = 2'b01;

    // R4 clear-on-match period sweep
    mode = 3'd1; com = 2'b01; cm_ie = 1'b1;
    for (int k = 0; k <= MAXV; k++) begin
      wr_ocr(k);
      cyc(40);
      wait_count(0);
      n = 0;
      do begin @(negedge clk); n++; end while (int'(count) != 0);
      check($sformatf("R4 period k=%0d", k), n, k + 1);
    end
    check("R4 match flag", int'(cm_flag), 1);
    check("R12 cm_irq", int'(cm_irq), 1);
    cm_ie = 1'b0;

    // R8 fast PWM duty sweeps
    mode = 3'd2;
    for (int p = 0; p < 2; p++) begin
      com = p ? 2'b11 : 2'b10;
      for (int k = 0; k <= MAXV; k++) begin
        wr_ocr(k); cyc(2 * FULL);
        measure(FULL, hi);
        check($sformatf("R8 fast inv=%0d k=%0d", p, k), hi, highs_fast(k, p[0]));
      end
    end
    ov_clr = 1'b1; cyc(1); ov_clr = 1'b0;
    cyc(FULL);
    check("R8 wrap flag", int'(ov_flag), 1);

    // R9 / R11 dual-slope duty sweeps
    for (int m = 3; m <= 4; m++) begin
      mode = 3'(m);
      for (int p = 0; p < 2; p++) begin
        com = p ? 2'b11 : 2'b10;
        for (int k = 0; k <= MAXV; k++) begin
          wr_ocr(k); cyc(2 * DPER);
          measure(DPER, hi);
          if (m == 3) check($sformatf("R9 pc inv=%0d k=%0d", p, k), hi, highs_dual(k, p[0]));
          else        check($sformatf("R11 pfc inv=%0d k=%0d", p, k), hi, highs_dual(k, p[0]));
        end
      end
    end
    ov_clr = 1'b1; cyc(1); ov_clr = 1'b0;
    cyc(DPER);
    check("R9 bottom flag", int'(ov_flag), 1);

    // R10 load point: top for fast and phase-correct, bottom for pfc
    mode = 3'd2; com = 2'b10; wr_ocr(3); cyc(2 * FULL);
    wait_count(1); wr_ocr(10);
    wait_count(6);
    check("R10 fast keeps old value", int'(oc_out), 0);
    wait_count(MAXV); wait_count(6);
    check("R10 fast new value at top", int'(oc_out), 1);
    for (int m = 3; m <= 4; m++) begin
      mode = 3'(m); wr_ocr(3); cyc(2 * DPER);
      wait_count(4); wait_count(5);
      wr_ocr(10);
      wait_count(MAXV); wait_count(8);
      check($sformatf("R10 dual mode=%0d down slope", m), int'(oc_out), (m == 3) ? 1 : 0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule